// File: doc/BRIEF.md
# Linear and Circular Address Sequencer

This block produces the address for one port of a data memory. It holds three registers: a current address, a window start and a window length. Each register has its own load strobe, and all three share one load data bus. A step input advances the current address by one per cycle. A processor places two independent copies beside its two data memories. During a pipelined inner product it holds the step input high, so each copy supplies a new operand address on every cycle.

A mode input is sampled on every step. It chooses between a plain linear walk and a circular walk inside the window. In a circular walk, stepping from the last word of the window (start + length − 1) returns the address to the start. A linear walk only wraps at the top of the address space. The mode can change from one step to the next without reloading anything. One preset therefore serves both linear and circular access patterns.

Top module: `addr_gen`

## Requirements
- R1: While rst_n is low, the current address, window start and window length are all cleared to 0, so addr reads 0 after reset.
- R2: A cycle with ld_base high writes ld_data into the current address, and addr shows the new value after that rising edge.
- R3: A step with wrap_en low and no load adds 1 to addr, modulo 2^AW (1023 steps to 0 for AW = 10).
- R4: A step with wrap_en high, a nonzero window length and addr equal to (start + length − 1) mod 2^AW sets addr to the window start.
- R5: A step with wrap_en high and no wrap condition adds 1 to addr, modulo 2^AW, including a window that crosses the top of the address space.
- R6: When any load strobe is high, step has no effect on addr in that cycle; ld_base still loads its value.
- R7: With step and all load strobes low, addr keeps its value.
- R8: With a window length of 0, a step in circular mode behaves like a linear step.
- R9: Loading the window start or the window length leaves addr unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_base | input | 1 | Load the current address from ld_data |
| ld_ofs | input | 1 | Load the window start from ld_data |
| ld_len | input | 1 | Load the window length from ld_data |
| ld_data | input | AW | Shared load value |
| step | input | 1 | Advance the address by one |
| wrap_en | input | 1 | 1: circular walk inside the window, 0: linear walk |
| addr | output | AW | Current address |

## Verification
The assertions assume that every strobe, wrap_en and ld_data hold known values at each rising edge after reset. They also compare addr with the internal window registers, so they assume nothing else writes those registers. The stimulus changes inputs only on falling edges and drives every input to a defined value in every cycle. It loads windows that end exactly at a step boundary, a window that crosses the top of the address space, and a window of length zero.

// File: rtl/addr_gen.sv
module addr_gen #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_base,
  input  logic          ld_ofs,
  input  logic          ld_len,
  input  logic [AW-1:0] ld_data,
  input  logic          step,
  input  logic          wrap_en,
  output logic [AW-1:0] addr
);

  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] cur_q, ofs_q, len_q;

  wire            ld_any = ld_base | ld_ofs | ld_len;
  wire [AW-1:0]   last   = ofs_q + len_q - ONE;
  wire            at_end = wrap_en && (len_q != '0) && (cur_q == last);
  wire [AW-1:0]   nxt    = at_end ? ofs_q : cur_q + ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      ofs_q <= '0;
      len_q <= '0;
    end else begin
      if (ld_ofs) ofs_q <= ld_data;
      if (ld_len) len_q <= ld_data;
      if (ld_base) cur_q <= ld_data;
      else if (step && !ld_any) cur_q <= nxt;
    end
  end

  assign addr = cur_q;

endmodule

// File: rtl/addr_gen_chk.sv
module addr_gen_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ld_base,
  input logic          ld_ofs,
  input logic          ld_len,
  input logic [AW-1:0] ld_data,
  input logic          step,
  input logic          wrap_en,
  input logic [AW-1:0] addr,
  input logic [AW-1:0] ofs_q,
  input logic [AW-1:0] len_q
);

  logic          any_ld;
  logic [AW-1:0] win_end;
  logic          wrap_hit;
  assign any_ld   = ld_base | ld_ofs | ld_len;
  assign win_end  = ofs_q + len_q - AW'(1);
  assign wrap_hit = wrap_en && (len_q != '0) && (addr == win_end);

  AST_BASE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_base |=> addr == $past(ld_data)); // R2

  AST_LIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !any_ld && !wrap_en) |=> addr == $past(addr) + AW'(1)); // R3

  AST_MOD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !any_ld && wrap_hit) |=> addr == $past(ofs_q)); // R4

  AST_MOD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !any_ld && wrap_en && !wrap_hit) |=> addr == $past(addr) + AW'(1)); // R5

  AST_LOAD_BLOCKS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld_base && (ld_ofs || ld_len)) |=> $stable(addr)); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !any_ld) |=> $stable(addr)); // R7

  AST_ZERO_LEN_LINEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !any_ld && wrap_en && len_q == '0) |=> addr == $past(addr) + AW'(1)); // R8

  AST_WIN_LOAD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    ((ld_ofs || ld_len) && !ld_base) |=> $stable(addr)); // R9

endmodule

bind addr_gen addr_gen_chk #(.AW(AW)) u_chk (.*);

// File: tb/addr_gen_tb.sv
`timescale 1ns/1ps
module addr_gen_tb;
  localparam int AW = 10;

  typedef struct {
    logic [AW-1:0] exp;
    string         req;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_base = 1'b0, ld_ofs = 1'b0, ld_len = 1'b0;
  logic [AW-1:0] ld_data = '0;
  logic          step = 1'b0, wrap_en = 1'b0;
  logic [AW-1:0] addr;

  int checks = 0, errors = 0;
  item_t sbq[$];
  logic [AW-1:0] m_cur = '0, m_ofs = '0, m_len = '0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  addr_gen #(.AW(AW)) u_dut (.*);

  task automatic drive(input bit b, input bit o, input bit l, input int d,
                       input bit s, input bit w, input string req);
    item_t it;
    logic [AW-1:0] dv;
    logic [AW-1:0] endp;
    @(negedge clk);
    dv = AW'(d);
    ld_base = b; ld_ofs = o; ld_len = l; ld_data = dv; step = s; wrap_en = w;
    endp = m_ofs + m_len - AW'(1);
    if (b) m_cur = dv;
    else if (s && !o && !l) begin
      if (w && m_len != 0 && m_cur == endp) m_cur = m_ofs;
      else m_cur = m_cur + AW'(1);
    end
    if (o) m_ofs = dv;
    if (l) m_len = dv;
    it.exp = m_cur;
    it.req = req;
    sbq.push_back(it);
  endtask

  always @(posedge clk) begin
    #1;
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      checks++;
      if (addr !== it.exp) begin
        errors++;
        $display("FAIL %s: addr=%0d expected=%0d", it.req, addr, it.exp);
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (addr !== '0) begin
      errors++;
      $display("FAIL R1: addr=%0d expected=0", addr);
    end
    rst_n = 1'b1;
    drive(0, 0, 0, 0, 1, 1, "R1");
    drive(0, 1, 0, 100, 0, 0, "R9");
    drive(0, 0, 1, 4, 0, 0, "R9");
    drive(1, 0, 0, 100, 0, 0, "R2");
    for (int i = 0; i < 6; i++) drive(0, 0, 0, 0, 1, 1, "R4_R5");
    for (int i = 0; i < 3; i++) drive(0, 0, 0, 0, 1, 0, "R3");
    drive(1, 0, 0, 7, 1, 1, "R6");
    drive(0, 0, 1, 4, 1, 0, "R6");
    drive(0, 1, 0, 100, 1, 1, "R6");
    for (int i = 0; i < 3; i++) drive(0, 0, 0, 0, 0, 1, "R7");
    drive(1, 0, 0, 1023, 0, 0, "R2");
    drive(0, 0, 0, 0, 1, 0, "R3");
    drive(0, 0, 1, 0, 0, 0, "R9");
    drive(1, 0, 0, 5, 0, 0, "R2");
    for (int i = 0; i < 3; i++) drive(0, 0, 0, 0, 1, 1, "R8");
    drive(0, 1, 0, 1020, 0, 0, "R9");
    drive(0, 0, 1, 8, 0, 0, "R9");
    drive(1, 0, 0, 1022, 0, 0, "R2");
    for (int i = 0; i < 12; i++) drive(0, 0, 0, 0, 1, 1, "R5_R4");
    drive(0, 0, 0, 0, 0, 0, "R7");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule